// File: doc/BRIEF.md
# UART Interrupt Status Controller

This block collects the interrupt events of a UART and sends them on to the interrupt controller. It holds eleven raw status bits. The UART datapath sets them with single-cycle pulses. Either the datapath or software clears them. A mask register selects which raw bits may reach the outputs. The masked bits are then grouped onto five dedicated interrupt lines: receive, transmit, receive timeout, modem status and error. A sixth line is the OR of all of them.

Software reaches the block through a simple register port, one request per cycle. There are four registers:

| Address | Access | Contents |
|---|---|---|
| 0 | read/write | mask |
| 1 | read-only | raw status |
| 2 | read-only | masked status |
| 3 | write-only | write-one-to-clear |

Read data is registered and appears on the cycle after the request. Every interrupt line is registered. A line reflects the raw and mask state that was in place before the clock edge that updates it.

Top module: `uart_irq_ctrl`

## Requirements
- R1: A pulse on `set_i[b]` sets raw bit b at the next clock edge. The bit positions are: 0 ring, 1 CTS, 2 DCD, 3 DSR, 4 receive, 5 transmit, 6 receive timeout, 7 framing, 8 parity, 9 break, 10 overrun. Reading address 1 returns the raw bits.
- R2: A write to address 0 loads the mask. A read of address 0 returns it.
- R3: A read of address 2 returns the raw bits ANDed with the mask, bit for bit.
- R4: `irq_rx_o`, `irq_tx_o` and `irq_rt_o` each follow exactly one masked bit: 4, 5 and 6 respectively.
- R5: `irq_err_o` is high when any of masked bits 10, 9, 8 or 7 is set.
- R6: `irq_ms_o` is high when any of masked bits 3, 2, 1 or 0 is set.
- R7: `irq_any_o` is the OR of all eleven masked bits.
- R8: A write to address 3 clears each raw bit whose position is 1 in the written value. All other raw bits are left unchanged. A read of address 3 returns 0.
- R9: A pulse on `hw_clr_i[b]` clears raw bit b at the next clock edge.
- R10: When a set and a clear (from hardware or software) reach the same bit in the same cycle, the bit ends up set.
- R11: Every output line is registered. A change to the raw bits or to the mask shows on the lines one cycle later, so a mask write re-evaluates all six lines.
- R12: Reset clears the raw bits, the mask, the read data and every line.
- R13: Writes to addresses 1 and 2 have no effect on any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| set_i | input | 11 | Per-source set pulses from the datapath |
| hw_clr_i | input | 11 | Per-source clear requests from the datapath |
| bus_req_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 2 | Register address |
| bus_wdata_i | input | 11 | Write data |
| bus_rdata_o | output | 11 | Registered read data |
| irq_any_o | output | 1 | Combined interrupt line |
| irq_rx_o | output | 1 | Receive line |
| irq_tx_o | output | 1 | Transmit line |
| irq_rt_o | output | 1 | Receive-timeout line |
| irq_ms_o | output | 1 | Modem-status line |
| irq_err_o | output | 1 | Error line |

## Verification
A hardware set pulse and a clear can land on the same raw bit in a single cycle. The clear may be a software write to address 3 or a datapath clear. The bench drives both cases on purpose: it pulses `set_i` together with a clear write or with `hw_clr_i` on the same bit. It then reads the raw register and watches the line that bit feeds, and both must show the bit still set. A reference model updates raw and mask in the same order as the hardware and is cross-checked every cycle. A long pseudo-random stretch then mixes sets, clears and mask writes so that such collisions also occur by chance.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int NSRC   = 11;
  localparam int NLINE  = 5;
  localparam int ADDR_W = 2;

  typedef logic [NSRC-1:0] src_t;

  localparam logic [ADDR_W-1:0] A_MASK  = 2'd0;
  localparam logic [ADDR_W-1:0] A_RAW   = 2'd1;
  localparam logic [ADDR_W-1:0] A_MSKD  = 2'd2;
  localparam logic [ADDR_W-1:0] A_CLEAR = 2'd3;

  // line index: 0 rx, 1 tx, 2 rt, 3 modem, 4 error
  localparam src_t LINE_SEL [NLINE] = '{
    11'h010, 11'h020, 11'h040, 11'h00F, 11'h780
  };
endpackage

// File: rtl/uart_irq_status.sv
module uart_irq_status
  import uart_irq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  src_t set_i,
  input  src_t hw_clr_i,
  input  src_t sw_clr_i,
  output src_t raw_o
);
  src_t raw_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) raw_q <= '0;
    else         raw_q <= (raw_q & ~(hw_clr_i | sw_clr_i)) | set_i;  // set wins
  end

  assign raw_o = raw_q;
endmodule

// File: rtl/uart_irq_regs.sv
module uart_irq_regs
  import uart_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  src_t              wdata_i,
  input  src_t              raw_i,
  output src_t              mask_o,
  output src_t              sw_clr_o,
  output src_t              rdata_o
);
  src_t mask_q, rdata_q, rd_val;
  logic wr, rd;

  assign wr = req_i & we_i;
  assign rd = req_i & ~we_i;
  assign sw_clr_o = (wr && addr_i == A_CLEAR) ? wdata_i : '0;

  always_comb begin
    unique case (addr_i)
      A_MASK:  rd_val = mask_q;
      A_RAW:   rd_val = raw_i;
      A_MSKD:  rd_val = raw_i & mask_q;
      default: rd_val = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q  <= '0;
      rdata_q <= '0;
    end else begin
      if (wr && addr_i == A_MASK) mask_q <= wdata_i;
      if (rd) rdata_q <= rd_val;
    end
  end

  assign mask_o  = mask_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/uart_irq_route.sv
module uart_irq_route
  import uart_irq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  src_t             masked_i,
  output logic [NLINE-1:0] line_o,
  output logic             any_o
);
  logic [NLINE-1:0] line_d, line_q;
  logic             any_q;

  for (genvar g = 0; g < NLINE; g++) begin : g_line
    assign line_d[g] = |(masked_i & LINE_SEL[g]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q <= '0;
      any_q  <= 1'b0;
    end else begin
      line_q <= line_d;
      any_q  <= |masked_i;
    end
  end

  assign line_o = line_q;
  assign any_o  = any_q;
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NSRC-1:0]   set_i,
  input  logic [NSRC-1:0]   hw_clr_i,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [NSRC-1:0]   bus_wdata_i,
  output logic [NSRC-1:0]   bus_rdata_o,
  output logic              irq_any_o,
  output logic              irq_rx_o,
  output logic              irq_tx_o,
  output logic              irq_rt_o,
  output logic              irq_ms_o,
  output logic              irq_err_o
);
  src_t raw, mask, sw_clr;
  logic [NLINE-1:0] lines;

  uart_irq_status u_status (
    .clk_i, .rst_ni, .set_i, .hw_clr_i,
    .sw_clr_i(sw_clr), .raw_o(raw)
  );

  uart_irq_regs u_regs (
    .clk_i, .rst_ni,
    .req_i(bus_req_i), .we_i(bus_we_i), .addr_i(bus_addr_i),
    .wdata_i(bus_wdata_i), .raw_i(raw),
    .mask_o(mask), .sw_clr_o(sw_clr), .rdata_o(bus_rdata_o)
  );

  uart_irq_route u_route (
    .clk_i, .rst_ni, .masked_i(raw & mask),
    .line_o(lines), .any_o(irq_any_o)
  );

  assign irq_rx_o  = lines[0];
  assign irq_tx_o  = lines[1];
  assign irq_rt_o  = lines[2];
  assign irq_ms_o  = lines[3];
  assign irq_err_o = lines[4];
endmodule

// File: rtl/uart_irq_ctrl_chk.sv
module uart_irq_ctrl_chk
  import uart_irq_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NSRC-1:0]   set_i,
  input logic [NSRC-1:0]   hw_clr_i,
  input logic              bus_req_i,
  input logic              bus_we_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [NSRC-1:0]   bus_wdata_i,
  input logic [NSRC-1:0]   raw,
  input logic [NSRC-1:0]   mask,
  input logic              irq_any_o,
  input logic              irq_rx_o,
  input logic              irq_tx_o,
  input logic              irq_rt_o,
  input logic              irq_ms_o,
  input logic              irq_err_o
);
  logic clr_wr, mask_wr;
  assign clr_wr  = bus_req_i && bus_we_i && bus_addr_i == A_CLEAR;
  assign mask_wr = bus_req_i && bus_we_i && bus_addr_i == A_MASK;

  assert_set_lands_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((raw & $past(set_i)) == $past(set_i)));

  assert_clear_works_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_wr && set_i == '0) |=> ((raw & $past(bus_wdata_i)) == '0));

  assert_hw_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hw_clr_i != '0 && set_i == '0) |=> ((raw & $past(hw_clr_i)) == '0));

  assert_mask_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_wr |=> (mask == $past(bus_wdata_i)));

  assert_rx_line_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (irq_rx_o == $past(raw[4] & mask[4])));

  assert_err_line_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (irq_err_o == |($past(raw & mask) & 11'h780)));

  assert_ms_line_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (irq_ms_o == |($past(raw & mask) & 11'h00F)));

  assert_any_line_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_any_o == (irq_rx_o | irq_tx_o | irq_rt_o | irq_ms_o | irq_err_o));
endmodule

bind uart_irq_ctrl uart_irq_ctrl_chk u_chk (
  .clk_i, .rst_ni, .set_i, .hw_clr_i, .bus_req_i, .bus_we_i, .bus_addr_i,
  .bus_wdata_i, .raw, .mask, .irq_any_o, .irq_rx_o, .irq_tx_o, .irq_rt_o,
  .irq_ms_o, .irq_err_o
);

// File: tb/tb_uart_irq_ctrl.sv
module tb_uart_irq_ctrl;
  logic clk = 0, rst_n = 0;
  logic [10:0] set_s = '0, hclr = '0, wdata = '0;
  logic req = 0, we = 0;
  logic [1:0] addr = '0;
  logic [10:0] rdata;
  logic any, rx, tx, rt, ms, err;

  always #2.5 clk = ~clk;

  uart_irq_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .set_i(set_s), .hw_clr_i(hclr),
    .bus_req_i(req), .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .irq_any_o(any), .irq_rx_o(rx), .irq_tx_o(tx),
    .irq_rt_o(rt), .irq_ms_o(ms), .irq_err_o(err)
  );

  typedef struct {
    logic [5:0]  lines;   // {any, err, ms, rt, tx, rx}
    logic        rd;
    logic [10:0] rdata;
    string       tag;
  } item_t;

  item_t q[$];
  int total = 0, bad = 0;
  logic [10:0] m_raw = '0, m_mask = '0;
  bit done = 0;

  function automatic logic [5:0] lines_of(logic [10:0] m);
    return {|m, |m[10:7], |m[3:0], m[6], m[5], m[4]};
  endfunction

  task automatic step(logic [10:0] s, logic [10:0] hc, logic rq, logic w,
                      logic [1:0] a, logic [10:0] d, string tag);
    item_t it;
    logic [10:0] clr;
    @(negedge clk);
    set_s = s; hclr = hc; req = rq; we = w; addr = a; wdata = d;
    it.lines = lines_of(m_raw & m_mask);
    it.rd = rq && !w;
    case (a)
      2'd0: it.rdata = m_mask;
      2'd1: it.rdata = m_raw;
      2'd2: it.rdata = m_raw & m_mask;
      default: it.rdata = '0;
    endcase
    it.tag = tag;
    q.push_back(it);
    clr = (rq && w && a == 2'd3) ? d : '0;
    m_raw = (m_raw & ~clr & ~hc) | s;
    if (rq && w && a == 2'd0) m_mask = d;
  endtask

  task automatic idle(string tag); step('0, '0, 0, 0, 2'd0, '0, tag); endtask
  task automatic rd_reg(logic [1:0] a, string tag); step('0, '0, 1, 0, a, '0, tag); endtask
  task automatic wr_reg(logic [1:0] a, logic [10:0] d, string tag); step('0, '0, 1, 1, a, d, tag); endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        item_t it;
        logic [5:0] got;
        it = q.pop_front();
        got = {any, err, ms, rt, tx, rx};
        total++;
        if (got !== it.lines) begin
          bad++;
          $display("FAIL %s lines actual=%b expected=%b", it.tag, got, it.lines);
        end
        if (it.rd) begin
          total++;
          if (rdata !== it.rdata) begin
            bad++;
            $display("FAIL %s rdata actual=%h expected=%h", it.tag, rdata, it.rdata);
          end
        end
      end
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(negedge clk);
    // R12 reset state
    total++;
    if ({any, err, ms, rt, tx, rx, rdata} !== '0) begin
      bad++;
      $display("FAIL R12 reset actual=%b expected=0", {any, err, ms, rt, tx, rx, rdata});
    end
    rst_n = 1;
    idle("R12");
    rd_reg(2'd1, "R12");
    rd_reg(2'd0, "R12");
    wr_reg(2'd0, 11'h7FF, "R2");
    rd_reg(2'd0, "R2");
    step(11'h010, '0, 0, 0, 0, '0, "R1");
    idle("R4");
    step(11'h060, '0, 0, 0, 0, '0, "R4");
    idle("R4");
    step(11'h100, '0, 0, 0, 0, '0, "R5");
    idle("R5");
    step(11'h004, '0, 0, 0, 0, '0, "R6");
    idle("R6");
    rd_reg(2'd1, "R1");
    wr_reg(2'd0, 11'h410, "R11");
    rd_reg(2'd2, "R3");
    idle("R11");
    wr_reg(2'd0, 11'h000, "R11");
    idle("R7");
    wr_reg(2'd0, 11'h7FF, "R11");
    wr_reg(2'd3, 11'h110, "R8");
    rd_reg(2'd1, "R8");
    rd_reg(2'd3, "R8");
    step('0, 11'h004, 0, 0, 0, '0, "R9");
    rd_reg(2'd1, "R9");
    step(11'h020, '0, 1, 1, 2'd3, 11'h020, "R10");
    rd_reg(2'd1, "R10");
    step(11'h040, 11'h040, 0, 0, 0, '0, "R10");
    rd_reg(2'd1, "R10");
    wr_reg(2'd1, 11'h000, "R13");
    wr_reg(2'd2, 11'h7FF, "R13");
    rd_reg(2'd1, "R13");
    rd_reg(2'd0, "R13");
    wr_reg(2'd3, 11'h7FF, "R8");
    idle("R7");
    lfsr = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (lfsr[2:0])
        3'd0: wr_reg(2'd0, lfsr[13:3], "R7");
        3'd1: wr_reg(2'd3, lfsr[14:4], "R8");
        3'd2: rd_reg(lfsr[4:3], "R3");
        3'd3: step(lfsr[13:3], lfsr[15:5], 1, 1, 2'd3, lfsr[12:2], "R10");
        3'd4: step('0, lfsr[14:4], 0, 0, 0, '0, "R9");
        default: step(lfsr[13:3] & lfsr[15:5], '0, 0, 0, 0, '0, "R7");
      endcase
    end
    idle("R7");
    idle("R7");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule